// File: doc/BRIEF.md
# USB Reset Bring-up Sequencer

This block carries out the power-on reset choreography for a USB subsystem that has ten device ports, two host controllers and three PHYs. A single-cycle start pulse makes the block do three things. It samples a module-disable status word and the present values of four 32-bit peripheral reset vectors. It works out which device ports need to go through reset. It then walks the reset vectors and three PHY run-state (RS) control bits through a fixed order of steps. A done flag signals the end of the sequence.

The block owns the four reset vector registers and the three RS bits. A bit that the sequence does not select keeps the value sampled at start, so resets that have nothing to do with USB pass through the sequence unchanged. The PHYs need a settle time between leaving reset and being put back into run state. This time is given in microseconds together with the clock frequency and is converted into a cycle count when the block is elaborated.

Top module: `usb_reset_seq`

## Requirements
- R1: After reset, all four reset vectors read 0, all three RS bits read 1, and busy and done read 0.
- R2: The disable word is decoded per group, and a 0 in a group bit selects the devices of that group. Bit 9 selects vector 0 bits 5, 8 and 25 plus vector 2 bit 4. Bit 22 selects vector 0 bits 22, 23 and 24 plus vector 2 bit 5. Bit 24 selects vector 2 bit 6. Bit 21 selects vector 2 bit 7.
- R3: Some bits are selected on every run, whatever the disable word holds. These are the host resets (vector 1 bit 26 and vector 3 bit 31) and the PHY resets (vector 2 bits 24 and 25 and vector 3 bit 25).
- R4: In the cycle after start is sampled, each vector equals its sampled prior value ORed with every selected device, host and PHY bit. busy reads 1, and the RS bits have not yet changed.
- R5: One cycle later, all three RS bits read 0.
- R6: One cycle after that, the PHY reset bits read 0, while the device and host bits stay asserted.
- R7: The RS bits return to 1 exactly SETTLE_CYCLES cycles after the PHY resets are released, where SETTLE_CYCLES = CLK_HZ/1e6 * SETTLE_US.
- R8: One cycle after the RS bits are set, the selected device and host bits read 0, done reads 1 and busy reads 0.
- R9: A bit that is not selected holds its sampled prior value through the whole sequence and after it.
- R10: While busy, the block ignores the start input and any change to the disable word or to the prior reset values.
- R11: done stays at 1 until the next accepted start, which clears it in the same cycle that step 1 is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse; sampled only while idle |
| modDisable | input | 32 | Module-disable status word |
| rstPrior0 | input | 32 | Present value of reset vector 0 |
| rstPrior1 | input | 32 | Present value of reset vector 1 |
| rstPrior2 | input | 32 | Present value of reset vector 2 |
| rstPrior3 | input | 32 | Present value of reset vector 3 |
| rstVec0 | output | 32 | Driven reset vector 0 |
| rstVec1 | output | 32 | Driven reset vector 1 |
| rstVec2 | output | 32 | Driven reset vector 2 |
| rstVec3 | output | 32 | Driven reset vector 3 |
| phyRs | output | 3 | PHY run-state control bits, one per PHY |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until the next start |

## Verification
Two events can land in the same cycle: a new start pulse and a sequence that is still running. The clearest case is a start that arrives in the middle of the settle wait. The bench provokes this by raising start halfway through the wait, and by scrambling the disable word and the prior values right after step 1. It judges the result by requiring that every later step matches the expected values computed from the first sampled inputs. It also requires that the RS bits rise on the exact cycle set by the original timeline. It then checks that a start arriving while done is high is accepted, and that this start clears done in the same cycle as the new step 1.

// File: rtl/usb_reset_seq_pkg.sv
package usb_reset_seq_pkg;
  localparam int VEC_W   = 32;
  localparam int NUM_VEC = 4;
  localparam int NUM_PHY = 3;

  typedef logic [VEC_W-1:0] vec_t;
  typedef vec_t [NUM_VEC-1:0] vecArr_t;

  // Strobes from control to datapath, one per sequence step
  typedef struct packed {
    logic load;    // step 1: capture and assert
    logic clrRs;   // step 2
    logic relPhy;  // step 3
    logic setRs;   // step 4
    logic relDev;  // step 5
  } seqStrobe_t;

  // Group select bits in the disable word
  localparam int GRP_D0_3 = 9;
  localparam int GRP_D4_7 = 22;
  localparam int GRP_D8   = 24;
  localparam int GRP_D9   = 21;

  // Fixed host and PHY positions
  localparam int HOST_A_BIT = 26;  // vector 1
  localparam int HOST_B_BIT = 31;  // vector 3
  localparam int PHY_A_BIT  = 24;  // vector 2
  localparam int PHY_B_BIT  = 25;  // vector 2
  localparam int PHY_C_BIT  = 25;  // vector 3

  function automatic vecArr_t devHostMask(input vec_t dis);
    vecArr_t m;
    m = '0;
    if (!dis[GRP_D0_3]) begin
      m[0][5] = 1'b1; m[0][8] = 1'b1; m[0][25] = 1'b1; m[2][4] = 1'b1;
    end
    if (!dis[GRP_D4_7]) begin
      m[0][22] = 1'b1; m[0][23] = 1'b1; m[0][24] = 1'b1; m[2][5] = 1'b1;
    end
    if (!dis[GRP_D8]) m[2][6] = 1'b1;
    if (!dis[GRP_D9]) m[2][7] = 1'b1;
    m[1][HOST_A_BIT] = 1'b1;
    m[3][HOST_B_BIT] = 1'b1;
    return m;
  endfunction

  function automatic vecArr_t phyMask();
    vecArr_t m;
    m = '0;
    m[2][PHY_A_BIT] = 1'b1;
    m[2][PHY_B_BIT] = 1'b1;
    m[3][PHY_C_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/usb_reset_seq_ctrl.sv
module usb_reset_seq_ctrl
  import usb_reset_seq_pkg::*;
#(
  parameter int SETTLE = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_RELPHY, S_WAIT, S_RELDEV} state_t;

  state_t     state, stateNxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE:   if (start) begin stb.load = 1'b1; stateNxt = S_CLR; end
      S_CLR:    begin stb.clrRs = 1'b1; stateNxt = S_RELPHY; end
      S_RELPHY: begin stb.relPhy = 1'b1; stateNxt = S_WAIT; end
      S_WAIT:   if (cnt == '0) begin stb.setRs = 1'b1; stateNxt = S_RELDEV; end
      S_RELDEV: begin stb.relDev = 1'b1; stateNxt = S_IDLE; end
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (stb.relPhy)
        cnt <= CNT_W'(SETTLE - 1);
      else if (state == S_WAIT && cnt != '0)
        cnt <= cnt - 1'b1;
      if (stb.load)
        done <= 1'b0;
      else if (stb.relDev)
        done <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/usb_reset_seq_dp.sv
module usb_reset_seq_dp
  import usb_reset_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           stb,
  input  vec_t                 disWord,
  input  vecArr_t              prior,
  output vecArr_t              vecOut,
  output logic [NUM_PHY-1:0]   rsOut
);
  vecArr_t vecReg, heldDev, phyM, newDev;

  assign phyM   = phyMask();
  assign newDev = devHostMask(disWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg  <= '0;
      heldDev <= '0;
      rsOut   <= '1;
    end else begin
      if (stb.load) heldDev <= newDev;
      for (int i = 0; i < NUM_VEC; i++) begin
        if (stb.load)
          vecReg[i] <= prior[i] | newDev[i] | phyM[i];
        else if (stb.relPhy)
          vecReg[i] <= vecReg[i] & ~phyM[i];
        else if (stb.relDev)
          vecReg[i] <= vecReg[i] & ~heldDev[i];
      end
      if (stb.clrRs)
        rsOut <= '0;
      else if (stb.setRs)
        rsOut <= '1;
    end
  end

  assign vecOut = vecReg;
endmodule

// File: rtl/usb_reset_seq.sv
module usb_reset_seq
  import usb_reset_seq_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SETTLE_US = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] modDisable,
  input  logic [31:0] rstPrior0,
  input  logic [31:0] rstPrior1,
  input  logic [31:0] rstPrior2,
  input  logic [31:0] rstPrior3,
  output logic [31:0] rstVec0,
  output logic [31:0] rstVec1,
  output logic [31:0] rstVec2,
  output logic [31:0] rstVec3,
  output logic [2:0]  phyRs,
  output logic        busy,
  output logic        done
);
  localparam int SETTLE_CYCLES = (CLK_HZ / 1_000_000) * SETTLE_US;

  seqStrobe_t stb;
  vecArr_t    prior, vecOut;

  assign prior = {rstPrior3, rstPrior2, rstPrior1, rstPrior0};

  usb_reset_seq_ctrl #(.SETTLE(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .stb(stb), .busy(busy), .done(done)
  );

  usb_reset_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .disWord(modDisable),
    .prior(prior), .vecOut(vecOut), .rsOut(phyRs)
  );

  assign rstVec0 = vecOut[0];
  assign rstVec1 = vecOut[1];
  assign rstVec2 = vecOut[2];
  assign rstVec3 = vecOut[3];
endmodule

// File: rtl/usb_reset_seq_chk.sv
module usb_reset_seq_chk #(
  parameter int SETTLE = 5000
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [31:0] rstVec1,
  input logic [31:0] rstVec2,
  input logic [31:0] rstVec3,
  input logic [2:0]  phyRs,
  input logic        busy,
  input logic        done
);
  logic        prevPhy;
  logic [31:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPhy <= 1'b0;
      gap     <= '0;
    end else begin
      prevPhy <= rstVec2[24];
      if (prevPhy && !rstVec2[24])
        gap <= 32'd1;
      else if (phyRs[0])
        gap <= '0;
      else if (gap != '0)
        gap <= gap + 1'b1;
    end
  end

  // R7
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyRs[0]) |-> gap == SETTLE);

  // R3
  fixed_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> rstVec3[31] && rstVec3[25] && rstVec2[24] && rstVec2[25] && rstVec1[26]);

  // R6
  host_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstVec2[24]) |-> rstVec3[31] && rstVec1[26] && phyRs == 3'b000);

  // R8
  finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !rstVec3[31] && !rstVec1[26] && phyRs == 3'b111 && !busy);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  // R5
  rs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyRs[0]) |-> busy && $onehot0(phyRs));
endmodule

bind usb_reset_seq usb_reset_seq_chk #(.SETTLE(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .rstVec1(rstVec1), .rstVec2(rstVec2),
  .rstVec3(rstVec3), .phyRs(phyRs), .busy(busy), .done(done)
);

// File: tb/usb_reset_seq_bench.sv
module usb_reset_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 50;  // 1 MHz * 50 us

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] modDisable = '0;
  logic [31:0] pr [4];
  logic [31:0] rv [4];
  logic [2:0]  phyRs;
  logic        busy, done;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_reset_seq #(.CLK_HZ(1_000_000), .SETTLE_US(50)) u_usb_reset_seq (
    .clk(clk), .rstN(rstN), .start(start), .modDisable(modDisable),
    .rstPrior0(pr[0]), .rstPrior1(pr[1]), .rstPrior2(pr[2]), .rstPrior3(pr[3]),
    .rstVec0(rv[0]), .rstVec1(rv[1]), .rstVec2(rv[2]), .rstVec3(rv[3]),
    .phyRs(phyRs), .busy(busy), .done(done)
  );

  function automatic logic [31:0] expDev(input logic [31:0] dis, input int idx);
    logic [31:0] m = '0;
    if (idx == 0) begin
      if (!dis[9])  m |= (32'd1 << 5) | (32'd1 << 8) | (32'd1 << 25);
      if (!dis[22]) m |= (32'd1 << 22) | (32'd1 << 23) | (32'd1 << 24);
    end else if (idx == 1) begin
      m = 32'd1 << 26;
    end else if (idx == 2) begin
      if (!dis[9])  m |= 32'd1 << 4;
      if (!dis[22]) m |= 32'd1 << 5;
      if (!dis[24]) m |= 32'd1 << 6;
      if (!dis[21]) m |= 32'd1 << 7;
    end else begin
      m = 32'd1 << 31;
    end
    return m;
  endfunction

  function automatic logic [31:0] expPhy(input int idx);
    if (idx == 2) return (32'd1 << 24) | (32'd1 << 25);
    if (idx == 3) return 32'd1 << 25;
    return '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runSeq(input logic [31:0] dis, input logic [31:0] p0, input logic [31:0] p1,
                        input logic [31:0] p2, input logic [31:0] p3, input bit poke);
    logic [31:0] snap [4];
    logic [31:0] s1 [4];
    logic [31:0] s3 [4];
    logic [31:0] s5 [4];
    snap[0] = p0; snap[1] = p1; snap[2] = p2; snap[3] = p3;
    for (int i = 0; i < 4; i++) begin
      s1[i] = snap[i] | expDev(dis, i) | expPhy(i);
      s3[i] = s1[i] & ~expPhy(i);
      s5[i] = s3[i] & ~expDev(dis, i);
    end
    @(negedge clk);
    modDisable = dis; pr[0] = p0; pr[1] = p1; pr[2] = p2; pr[3] = p3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) chk("R4 step1 vector (R2 R3 R9)", rv[i], s1[i]);
    chk("R4 rs unchanged", {29'd0, phyRs}, 32'd7);
    chk("R4 busy", {31'd0, busy}, 32'd1);
    chk("R11 done cleared by start", {31'd0, done}, 32'd0);
    if (poke) begin
      modDisable = $urandom; for (int i = 0; i < 4; i++) pr[i] = $urandom;
    end
    @(negedge clk);
    chk("R5 rs cleared", {29'd0, phyRs}, 32'd0);
    for (int i = 0; i < 4; i++) chk("R5 vectors held", rv[i], s1[i]);
    @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R6 phy released", rv[i], s3[i]);
    for (int k = 1; k < SETTLE; k++) begin
      @(negedge clk);
      if (poke && k == SETTLE/2) start = 1'b1;
      if (poke && k == SETTLE/2 + 1) start = 1'b0;
    end
    chk("R7 rs still low before settle", {29'd0, phyRs}, 32'd0);
    chk("R10 busy during wait", {31'd0, busy}, 32'd1);
    start = 1'b0;
    @(negedge clk);
    chk("R7 rs set after settle", {29'd0, phyRs}, 32'd7);
    for (int i = 0; i < 4; i++) chk("R8 devices held until rs set", rv[i], s3[i]);
    @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R8 R9 R10 final vector", rv[i], s5[i]);
    chk("R8 done", {30'd0, busy, done}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R11 done held", {31'd0, done}, 32'd1);
    for (int i = 0; i < 4; i++) chk("R9 final held", rv[i], s5[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4; i++) pr[i] = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R1 reset vector", rv[i], 32'd0);
    chk("R1 reset rs", {29'd0, phyRs}, 32'd7);
    chk("R1 reset flags", {30'd0, busy, done}, 32'd0);
    rstN = 1'b1;
    // directed: every group enabled for reset, none, and each group alone
    runSeq(32'h0000_0000, '0, '0, '0, '0, 1'b0);
    runSeq(32'hFFFF_FFFF, '0, '0, '0, '0, 1'b0);
    runSeq(~(32'd1 << 9),  32'hA5A5_A5A5, 32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 1'b0);
    runSeq(~(32'd1 << 22), 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1);
    runSeq(~(32'd1 << 24), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    runSeq(~(32'd1 << 21), 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h3333_3333, 32'hCCCC_CCCC, 1'b0);
    // random
    for (int n = 0; n < 14; n++)
      runSeq($urandom, $urandom, $urandom, $urandom, $urandom, n[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule